// File: doc/BRIEF.md
# Multi-Mode Sample FIFO

This block buffers three-axis sample sets (one X, one Y and one Z value captured together) in a queue of `DEPTH` entries, 32 by default. A 2-bit mode input picks the fill policy. In pass-through mode nothing is stored and only the latest sample is shown. In hold mode filling stops when the queue is full. In rolling mode the oldest set is overwritten. In triggered mode the queue rolls until a trigger arrives and then holds. A select input picks which of two trigger sources arms the triggered mode.

The consumer pops the oldest set with a read strobe, and the set appears on the three output buses. Four status outputs are always valid: a watermark flag that compares the fill level with a programmed threshold, a sticky overrun flag, an empty flag and the fill level itself. Routing these flags to interrupt pins and reaching them through a register bus are left to the surrounding logic.

Top module: `sample_fifo3`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with no other stimulus, `st_level` is 0, `st_empty` is 1, `st_ovr` is 0 and all three output buses are 0.
- R2: With `mode` = 2'b00 (pass-through) nothing is stored and `st_level` stays 0. Each `in_valid` sample appears on `out_x/out_y/out_z` at the next clock edge. `rd_en` has no effect.
- R3: With `mode` = 2'b01 (hold) the level never exceeds `DEPTH`. A sample that arrives while the queue is full and no pop happens in the same cycle is dropped, and the stored contents do not change.
- R4: With `mode` = 2'b10 (rolling), a sample that arrives while the queue is full and no pop happens in the same cycle removes the oldest set and is appended. The level stays at `DEPTH`.
- R5: With `mode` = 2'b11 (triggered) the queue acts as rolling mode until the selected trigger is high at a clock edge. The selected trigger is `trig_b` when `trig_sel` = 1 and `trig_a` when `trig_sel` = 0. From the next cycle the queue acts as hold mode. The armed state is cleared whenever `mode` is not 2'b11.
- R6: In any storing mode, `rd_en` with a non-empty queue loads the oldest set onto the output buses at the next edge and lowers the level by one. `rd_en` on an empty queue changes neither the outputs nor the level.
- R7: `st_wtm` is 1 exactly when `st_level` is greater than or equal to `wtm_level`.
- R8: `st_ovr` is set in the edge where a sample is dropped (R3) or where the oldest set is overwritten (R4). It is cleared in an edge where a pop leaves the level below `DEPTH` and no sample is lost.
- R9: Selecting pass-through mode empties the queue and clears `st_ovr` at the next edge.
- R10: When the queue is full and a pop and a sample happen in the same cycle, the sample is stored in every storing mode. The level stays at `DEPTH` and `st_ovr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Fill policy: 00 pass-through, 01 hold, 10 rolling, 11 triggered |
| wtm_level | input | 5 | Watermark threshold |
| trig_sel | input | 1 | Trigger source select (1 selects trig_b) |
| trig_a | input | 1 | Trigger source 0 |
| trig_b | input | 1 | Trigger source 1 |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 10 | X sample |
| in_y | input | 10 | Y sample |
| in_z | input | 10 | Z sample |
| rd_en | input | 1 | Pop the oldest set |
| out_x | output | 10 | Output X |
| out_y | output | 10 | Output Y |
| out_z | output | 10 | Output Z |
| st_wtm | output | 1 | Level at or above threshold |
| st_ovr | output | 1 | Sticky overrun flag |
| st_empty | output | 1 | Queue empty |
| st_level | output | 6 | Fill level, 0 to DEPTH |

## Verification
The output buses, the level and the overrun flag all come from registers. Their results are due exactly one clock edge after the inputs that cause them. The watermark and empty flags are decoded from the registered level, so they change in that same cycle. The trigger passes through one extra register before it changes the fill policy, so a trigger affects samples only from the following cycle on. The bench drives each stimulus on a falling edge and updates its reference queue with that stimulus. It then compares every output on the next falling edge, half a period after the edge that acts on the stimulus.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    parameter int SAMPLE_W = 10;

    typedef struct packed {
        logic [SAMPLE_W-1:0] x;
        logic [SAMPLE_W-1:0] y;
        logic [SAMPLE_W-1:0] z;
    } triple_t;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'b00,
        MODE_HOLD    = 2'b01,
        MODE_ROLL    = 2'b10,
        MODE_TRIGGER = 2'b11
    } fifo_mode_e;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_STOP = 2'b01,
        POL_WRAP = 2'b10
    } policy_e;

    function automatic policy_e decode_policy(input fifo_mode_e m, input logic armed);
        policy_e p;
        case (m)
            MODE_HOLD:    p = POL_STOP;
            MODE_ROLL:    p = POL_WRAP;
            MODE_TRIGGER: p = armed ? POL_STOP : POL_WRAP;
            default:      p = POL_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sfifo_policy.sv
module sfifo_policy
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fifo_mode_e mode_i,
    input  logic       trig_sel_i,
    input  logic       trig_a_i,
    input  logic       trig_b_i,
    output policy_e    pol_o
);
    logic armed_q;
    logic trig_hit;

    assign trig_hit = trig_sel_i ? trig_b_i : trig_a_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (mode_i != MODE_TRIGGER) begin
            armed_q <= 1'b0;
        end else if (trig_hit) begin
            armed_q <= 1'b1;
        end
    end

    assign pol_o = decode_policy(mode_i, armed_q);
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  policy_e          pol_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [PTR_W-1:0] rd_addr_o,
    output logic             pop_ok_o,
    output logic [LVL_W-1:0] level_o,
    output logic             ovr_o
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] cnt_q, cnt_n;
    logic             ovr_q;
    logic             active, full, empty, room, displace, drop, advance_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign active     = (pol_i != POL_OFF);
    assign full       = (cnt_q == FULL_LVL);
    assign empty      = (cnt_q == '0);
    assign pop_ok_o   = active && pop_i && !empty;
    assign room       = !full || pop_ok_o;
    assign displace   = (pol_i == POL_WRAP) && push_i && !room;
    assign drop       = (pol_i == POL_STOP) && push_i && !room;
    assign wr_en_o    = active && push_i && (room || displace);
    assign advance_rd = pop_ok_o || displace;

    always_comb begin
        cnt_n = cnt_q;
        if (wr_en_o && !displace) cnt_n = cnt_n + 1'b1;
        if (pop_ok_o)             cnt_n = cnt_n - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (wr_en_o)    wp_q <= bump(wp_q);
            if (advance_rd) rp_q <= bump(rp_q);
            cnt_q <= cnt_n;
            if (drop || displace) begin
                ovr_q <= 1'b1;
            end else if (pop_ok_o && cnt_n != FULL_LVL) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign wr_addr_o = wp_q;
    assign rd_addr_o = rp_q;
    assign level_o   = cnt_q;
    assign ovr_o     = ovr_q;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_addr_i,
    input  triple_t          wr_data_i,
    input  logic [PTR_W-1:0] rd_addr_i,
    output triple_t          rd_data_o
);
    triple_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) slots[wr_addr_i] <= wr_data_i;
    end

    assign rd_data_o = slots[rd_addr_i];
endmodule

// File: rtl/sfifo_outreg.sv
module sfifo_outreg
    import sfifo_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    direct_ld_i,
    input  triple_t direct_i,
    input  logic    pop_ld_i,
    input  triple_t head_i,
    output triple_t out_o
);
    triple_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (direct_ld_i) begin
            out_q <= direct_i;
        end else if (pop_ld_i) begin
            out_q <= head_i;
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/sample_fifo3.sv
module sample_fifo3
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [PTR_W-1:0]    wtm_level,
    input  logic                trig_sel,
    input  logic                trig_a,
    input  logic                trig_b,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_x,
    input  logic [SAMPLE_W-1:0] in_y,
    input  logic [SAMPLE_W-1:0] in_z,
    input  logic                rd_en,
    output logic [SAMPLE_W-1:0] out_x,
    output logic [SAMPLE_W-1:0] out_y,
    output logic [SAMPLE_W-1:0] out_z,
    output logic                st_wtm,
    output logic                st_ovr,
    output logic                st_empty,
    output logic [LVL_W-1:0]    st_level
);
    policy_e          pol;
    triple_t          sample, head, shown;
    logic             wr_en, pop_ok;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [LVL_W-1:0] level;

    assign sample = '{x: in_x, y: in_y, z: in_z};

    sfifo_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (fifo_mode_e'(mode)),
        .trig_sel_i (trig_sel),
        .trig_a_i   (trig_a),
        .trig_b_i   (trig_b),
        .pol_o      (pol)
    );

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pol_i     (pol),
        .push_i    (in_valid),
        .pop_i     (rd_en),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .pop_ok_o  (pop_ok),
        .level_o   (level),
        .ovr_o     (st_ovr)
    );

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (sample),
        .rd_addr_i (rd_addr),
        .rd_data_o (head)
    );

    sfifo_outreg u_out (
        .clk         (clk),
        .rst         (rst),
        .direct_ld_i ((pol == POL_OFF) && in_valid),
        .direct_i    (sample),
        .pop_ld_i    (pop_ok),
        .head_i      (head),
        .out_o       (shown)
    );

    assign out_x    = shown.x;
    assign out_y    = shown.y;
    assign out_z    = shown.z;
    assign st_level = level;
    assign st_empty = (level == '0);
    assign st_wtm   = (level >= {1'b0, wtm_level});
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             in_valid,
    input logic             rd_en,
    input logic             st_ovr,
    input logic             st_empty,
    input logic [LVL_W-1:0] st_level
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        st_level <= FULL_LVL);

    p_pass_flush_r9: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b00 |=> st_level == '0 && !st_ovr);

    p_hold_drop_r3: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b01 && st_level == FULL_LVL && in_valid && !rd_en
        |=> st_level == FULL_LVL && st_ovr);

    p_roll_over_r4: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 && st_level == FULL_LVL && in_valid && !rd_en
        |=> st_level == FULL_LVL && st_ovr);

    p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b00 && rd_en && !st_empty && !in_valid
        |=> st_level == $past(st_level) - 1'b1);

    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b00 && rd_en && !st_empty && !in_valid |=> !st_ovr);

    p_full_swap_r10: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b00 && st_level == FULL_LVL && in_valid && rd_en
        |=> st_level == FULL_LVL && st_ovr == $past(st_ovr));
endmodule

bind sample_fifo3 sfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .in_valid (in_valid),
    .rd_en    (rd_en),
    .st_ovr   (st_ovr),
    .st_empty (st_empty),
    .st_level (st_level)
);

// File: tb/sim_sample_fifo3.sv
module sim_sample_fifo3;
    localparam int DEPTH = 32;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic [4:0]    wtm_level = 5'd0;
    logic          trig_sel = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
    logic          in_valid = 1'b0, rd_en = 1'b0;
    logic [SW-1:0] in_x = '0, in_y = '0, in_z = '0;
    logic [SW-1:0] out_x, out_y, out_z;
    logic          st_wtm, st_ovr, st_empty;
    logic [5:0]    st_level;

    always #2 clk = ~clk;

    sample_fifo3 u0 (
        .clk(clk), .rst(rst), .mode(mode), .wtm_level(wtm_level),
        .trig_sel(trig_sel), .trig_a(trig_a), .trig_b(trig_b),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .rd_en(rd_en), .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .st_wtm(st_wtm), .st_ovr(st_ovr), .st_empty(st_empty), .st_level(st_level)
    );

    logic [29:0] q[$];
    logic [29:0] m_out = '0;
    bit          m_ovr = 0, m_arm = 0;
    int          n_chk = 0, n_fail = 0, seq = 1;
    bit          done = 0;
    int unsigned lfsr = 32'hACE1_2345;

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic compare(input string tag);
        chk({tag, " out"}, {out_x, out_y, out_z}, m_out);
        chk("R8 ovr", st_ovr, m_ovr);
        chk("R6 level", st_level, q.size());
        chk("R6 empty", st_empty, q.size() == 0);
        chk("R7 wtm", st_wtm, q.size() >= wtm_level);
    endtask

    // one cycle: drive at falling edge, advance reference, compare at next falling edge
    task automatic step(input bit v, input bit r, input string tag);
        logic [29:0] s;
        bit pop, stop, lost;
        int c;
        s = {SW'(seq), ~SW'(seq), SW'(seq) ^ 10'h2A5};
        seq++;
        in_valid = v; rd_en = r;
        {in_x, in_y, in_z} = s;
        if (mode == 2'b00) begin
            q.delete();
            m_ovr = 0;
            if (v) m_out = s;
        end else begin
            c = q.size();
            pop = r && c > 0;
            stop = (mode == 2'b01) || (mode == 2'b11 && m_arm);
            lost = 0;
            if (pop) m_out = q.pop_front();
            if (v) begin
                if (c < DEPTH || pop) q.push_back(s);
                else if (stop) lost = 1;
                else begin void'(q.pop_front()); q.push_back(s); lost = 1; end
            end
            if (lost) m_ovr = 1;
            else if (pop && q.size() < DEPTH) m_ovr = 0;
        end
        m_arm = (mode == 2'b11) && (m_arm || (trig_sel ? trig_b : trig_a));
        @(negedge clk);
        in_valid = 0; rd_en = 0; trig_a = 0; trig_b = 0;
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 level in reset", st_level, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 empty", st_empty, 1);
        chk("R1 ovr", st_ovr, 0);
        chk("R1 level", st_level, 0);
        chk("R1 out", {out_x, out_y, out_z}, 0);

        // R2 pass-through, reads ignored
        mode = 2'b00;
        for (int i = 0; i < 12; i++) step(i % 3 != 0, i % 2 == 0, "R2");

        // R3 hold mode fill past full, R8 overrun, R6 pop order
        mode = 2'b01;
        for (int i = 0; i < 40; i++) step(1, 0, "R3");
        chk("R3 full level", st_level, DEPTH);
        chk("R8 ovr after drop", st_ovr, 1);
        for (int i = 0; i < 8; i++) step(0, 1, "R6");
        chk("R8 ovr cleared", st_ovr, 0);
        mode = 2'b00; step(0, 0, "R9");
        chk("R9 flushed", st_level, 0);

        // R4 rolling overwrite, then drain
        mode = 2'b10;
        for (int i = 0; i < 45; i++) step(1, 0, "R4");
        for (int i = 0; i < 34; i++) step(0, 1, "R4 drain");
        chk("R6 empty after drain", st_empty, 1);

        // R10 simultaneous push and pop at full in each storing mode
        for (int md = 1; md < 4; md++) begin
            mode = 2'b00; step(0, 0, "R9");
            mode = 2'(md);
            for (int i = 0; i < 33; i++) step(1, 0, "R10 fill");
            for (int i = 0; i < 5; i++) step(1, 1, "R10");
            chk("R10 level", st_level, DEPTH);
        end

        // R5 triggered mode with each trigger source
        for (int sel = 0; sel < 2; sel++) begin
            mode = 2'b00; step(0, 0, "R9");
            mode = 2'b11; trig_sel = sel[0];
            for (int i = 0; i < 36; i++) begin
                if (sel == 0) trig_b = 1; else trig_a = 1;  // unselected source: no effect
                step(1, 0, "R5 rolling");
            end
            if (sel == 0) trig_a = 1; else trig_b = 1;
            step(1, 0, "R5 trigger");
            for (int i = 0; i < 4; i++) step(1, 0, "R5 hold");
            for (int i = 0; i < 33; i++) step(0, 1, "R5 drain");
        end

        // R7 watermark sweep over every threshold
        for (int wl = 0; wl < 32; wl++) begin
            wtm_level = 5'(wl);
            mode = 2'b00; step(0, 0, "R9");
            mode = 2'b01;
            for (int i = 0; i < 33; i++) step(1, 0, "R7");
        end

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = rnd();
            if (r[4:0] == 0) mode = r[6:5];
            if (r[12:9] == 0) wtm_level = r[17:13];
            trig_sel = r[18];
            trig_a = (r[23:20] == 0);
            trig_b = (r[27:24] == 0);
            step(r[28] | r[29], r[30], "R6 mixed");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule